// File: doc/BRIEF.md
# SPI Serial EEPROM Command Controller

This block is the serial-bus slave and write-protection logic for a 512-byte nonvolatile byte store. A host drives chip select, serial clock and serial data in mode 0 style: the block samples input data on rising clock edges and updates its output bit after falling edges. All four pins are synchronised into the block's own clock domain, so the serial clock must run well below the system clock (each half period lasts at least four system cycles).

Three instructions are recognised: one that arms the write-enable latch, a page write and a streaming read. The ninth address bit rides in bit 3 of the instruction byte, and the following byte supplies the low eight address bits. A write collects up to one 16-byte page into a buffer. When chip select returns high, the write is committed only if the latch is armed, the write-protect pin has stayed high for the whole frame, the target lies outside the block-protected region and the frame ended on a whole byte. The commit then runs as a self-timed cycle of `WRITE_CYCLES` clocks, modelled by a busy counter that moves the buffer into a behavioural register array one byte per clock.

Reads stream bytes from any start address until chip select rises. The address counter runs over the whole array and wraps from the last byte to the first.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: `spi_miso_oe` is low whenever no frame is open; it rises only after a chip-select falling edge and drops within a few clocks of chip select returning high.
- R2: After reset, no instruction is accepted until chip select has gone from high to low; clocking bits with chip select held low since reset has no effect.
- R3: Instruction 0x06 arms the write-enable latch; 0x02 is a write and 0x03 a read, and in both bit 3 of the instruction byte is address bit 8 (0x0A and 0x0B address the upper 256 bytes).
- R4: A write commits only when chip select rises after a whole number of bytes with at least one data byte; a frame ending mid-byte or before any data byte is rejected.
- R5: Data bytes land at successive columns of the 16-byte page that holds the start address, the low four address bits wrapping inside that page; when more than 16 bytes are sent, later bytes overwrite earlier ones.
- R6: A write with the write-enable latch clear does not change the array.
- R7: The write-enable latch clears when a commit finishes and when a write frame is rejected.
- R8: If `wp_n` is low at any moment while a write frame is open, including at the chip-select rise, that write is discarded; `wp_n` falling after the commit has begun does not stop it.
- R9: `blk_prot` selects the protected region: 0 none, 1 addresses 0x180 to 0x1FF, 2 addresses 0x100 to 0x1FF, 3 the whole array; a write whose start address lies in it is rejected.
- R10: A commit keeps `wr_busy` high for exactly `WRITE_CYCLES` clocks, and every frame that starts while `wr_busy` is high is ignored.
- R11: A read returns the byte at the start address MSB first, the first bit valid after the falling clock edge that ends the address byte, then continues with the next addresses, wrapping from 0x1FF to 0x000.
- R12: After reset the array holds 0x00 in every byte, the write-enable latch is clear and `wr_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write protect, low blocks writes |
| blk_prot | input | 2 | Block-protect selection (R9 encoding) |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (high drives the line) |
| wr_busy | output | 1 | High while a self-timed write is running |

## Verification
The bench builds the block with its default 16-byte page and `WRITE_CYCLES` cut to 600. That is short enough to allow a full 512-byte read sweep, a sweep of every `blk_prot` setting against every quarter of the array, and over-long and wrapping page writes, all in one run. It is also long enough that complete enable and write frames fit inside one busy window, so the rule that frames arriving during a commit are ignored can be observed at the pins.

// File: rtl/eeprom_pkg.sv
`timescale 1ns/100ps
package eeprom_pkg;
  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [7:0] OP_ARM = 8'h06;

  typedef enum logic [1:0] {CMD_NONE, CMD_ARM, CMD_WRITE, CMD_READ} cmd_e;

  // Instruction byte: bit 3 carries address bit 8 for write and read.
  function automatic cmd_e op_decode(input logic [7:0] b);
    if (b == OP_ARM)                               return CMD_ARM;
    else if (b[7:4] == 4'h0 && b[2:0] == 3'b010)   return CMD_WRITE;
    else if (b[7:4] == 4'h0 && b[2:0] == 3'b011)   return CMD_READ;
    else                                           return CMD_NONE;
  endfunction

  // Protection by quarters counted from the top of the array.
  function automatic logic in_locked_zone(input logic [ADDR_W-1:0] a,
                                          input logic [1:0] sel);
    case (sel)
      2'd0:    return 1'b0;
      2'd1:    return a[ADDR_W-1 -: 2] == 2'b11;
      2'd2:    return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/100ps
module spi_in_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/spi_front.sv
`timescale 1ns/100ps
module spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic mosi_pin,
  input  logic wp_n_pin,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic mosi_s,
  output logic wp_ok
);
  localparam int NSIG = 4;
  logic [NSIG-1:0] raw, synced;
  logic            sck_q, cs_q;

  assign raw = {wp_n_pin, cs_n_pin, sck_pin, mosi_pin};

  // Chip select synchronises to 0 at reset: a pin already low then makes no falling edge.
  spi_in_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw), .d_out(synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= synced[1];
      cs_q  <= synced[2];
    end
  end

  assign mosi_s   = synced[0];
  assign sck_rise = synced[1] & ~sck_q;
  assign sck_fall = ~synced[1] & sck_q;
  assign cs_fall  = ~synced[2] & cs_q;
  assign cs_rise  = synced[2] & ~cs_q;
  assign wp_ok    = synced[3];
endmodule

// File: rtl/eeprom_store.sv
`timescale 1ns/100ps
module eeprom_store
  import eeprom_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 2_000_000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
  input  logic [PAGE_BYTES-1:0][BYTE_W-1:0]    page_data,
  input  logic [PAGE_BYTES-1:0]                page_mask,
  input  logic [ADDR_W-1:0]                    rd_addr,
  output logic [BYTE_W-1:0]                    rd_data,
  output logic                                 busy,
  output logic                                 done
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WRITE_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [COL_W-1:0]  col;
  logic              col_live;

  assign col      = cnt[COL_W-1:0];
  assign col_live = busy && (int'(cnt) < PAGE_BYTES) && page_mask[col];
  assign done     = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (done) busy <= 1'b0;
    end
  end

  // One page column per clock during the first PAGE_BYTES clocks of the cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (col_live) begin
      mem[{page_base, col}] <= page_data[col];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
`timescale 1ns/100ps
module eeprom_cmd_ctrl
  import eeprom_pkg::*;
#(
  parameter int PAGE_BYTES = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sck_rise,
  input  logic                                 sck_fall,
  input  logic                                 cs_fall,
  input  logic                                 cs_rise,
  input  logic                                 mosi_s,
  input  logic                                 wp_ok,
  input  logic [1:0]                           blk_prot,
  input  logic                                 store_busy,
  input  logic                                 store_done,
  input  logic [BYTE_W-1:0]                    rd_data,
  output logic                                 start,
  output logic [ADDR_W-1:0]                    rd_addr,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
  output logic [PAGE_BYTES-1:0][BYTE_W-1:0]    page_data,
  output logic [PAGE_BYTES-1:0]                page_mask,
  output logic                                 miso,
  output logic                                 miso_oe,
  output logic                                 wel_o,
  output logic [2:0]                           bit_pos_o,
  output logic                                 active_o
);
  localparam int COL_W = $clog2(PAGE_BYTES);

  logic              active, ignore, wel, wp_abort, have_data;
  cmd_e              cmd, dec;
  logic [2:0]        bit_cnt;
  logic [1:0]        byte_idx;
  logic [6:0]        sh;
  logic [7:0]        in_byte;
  logic [ADDR_W-1:0] addr, rd_ptr;
  logic [COL_W-1:0]  wr_col;
  logic [6:0]        out_sh;
  logic              commit_ok;

  assign in_byte = {sh, mosi_s};
  assign dec     = op_decode(in_byte);

  assign commit_ok = (cmd == CMD_WRITE) && !ignore && wel && !wp_abort && wp_ok &&
                     (bit_cnt == 3'd0) && have_data && !in_locked_zone(addr, blk_prot);
  assign start = cs_rise && active && commit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      ignore    <= 1'b0;
      wel       <= 1'b0;
      wp_abort  <= 1'b0;
      have_data <= 1'b0;
      cmd       <= CMD_NONE;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      sh        <= '0;
      addr      <= '0;
      rd_ptr    <= '0;
      wr_col    <= '0;
      out_sh    <= '0;
      miso      <= 1'b0;
      page_data <= '0;
      page_mask <= '0;
    end else begin
      if (store_done) wel <= 1'b0;
      if (cs_fall) begin
        active    <= 1'b1;
        ignore    <= store_busy;
        bit_cnt   <= '0;
        byte_idx  <= '0;
        cmd       <= CMD_NONE;
        wp_abort  <= !wp_ok;
        have_data <= 1'b0;
        miso      <= 1'b0;
        if (!store_busy) page_mask <= '0;
      end else if (cs_rise && active) begin
        active <= 1'b0;
        if (cmd == CMD_WRITE && !ignore && !commit_ok) wel <= 1'b0;
      end else if (active && !ignore) begin
        if (!wp_ok) wp_abort <= 1'b1;
        if (sck_rise) begin
          sh      <= in_byte[6:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 3'd7) begin
            case (byte_idx)
              2'd0: begin
                cmd              <= dec;
                addr[ADDR_W-1]   <= in_byte[3];
                byte_idx         <= 2'd1;
                if (dec == CMD_ARM) wel <= 1'b1;
              end
              2'd1: begin
                addr[7:0] <= in_byte;
                rd_ptr    <= {addr[ADDR_W-1], in_byte};
                wr_col    <= in_byte[COL_W-1:0];
                byte_idx  <= 2'd2;
              end
              default: begin
                if (cmd == CMD_WRITE) begin
                  page_data[wr_col] <= in_byte;
                  page_mask[wr_col] <= 1'b1;
                  wr_col            <= wr_col + 1'b1;
                  have_data         <= 1'b1;
                end
              end
            endcase
          end
        end
        if (sck_fall && cmd == CMD_READ && byte_idx == 2'd2) begin
          if (bit_cnt == 3'd0) begin
            miso   <= rd_data[7];
            out_sh <= rd_data[6:0];
            rd_ptr <= rd_ptr + 1'b1;
          end else begin
            miso   <= out_sh[6];
            out_sh <= {out_sh[5:0], 1'b0};
          end
        end
      end
    end
  end

  assign rd_addr   = rd_ptr;
  assign page_base = addr[ADDR_W-1:COL_W];
  assign miso_oe   = active;
  assign wel_o     = wel;
  assign bit_pos_o = bit_cnt;
  assign active_o  = active;
endmodule

// File: rtl/spi_eeprom_ctrl.sv
`timescale 1ns/100ps
module spi_eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 2_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  input  logic       wp_n,
  input  logic [1:0] blk_prot,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic       wr_busy
);
  localparam int COL_W = $clog2(PAGE_BYTES);

  logic sck_rise, sck_fall, cs_fall, cs_rise, mosi_s, wp_ok;
  logic start, done, wel, frame_active;
  logic [2:0]                        bit_pos;
  logic [ADDR_W-1:0]                 rd_addr;
  logic [BYTE_W-1:0]                 rd_data;
  logic [ADDR_W-COL_W-1:0]           page_base;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] page_data;
  logic [PAGE_BYTES-1:0]             page_mask;

  spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .cs_n_pin(spi_cs_n), .sck_pin(spi_sck), .mosi_pin(spi_mosi), .wp_n_pin(wp_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .mosi_s(mosi_s), .wp_ok(wp_ok)
  );

  eeprom_cmd_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .mosi_s(mosi_s), .wp_ok(wp_ok), .blk_prot(blk_prot),
    .store_busy(wr_busy), .store_done(done), .rd_data(rd_data),
    .start(start), .rd_addr(rd_addr), .page_base(page_base),
    .page_data(page_data), .page_mask(page_mask),
    .miso(spi_miso), .miso_oe(spi_miso_oe),
    .wel_o(wel), .bit_pos_o(bit_pos), .active_o(frame_active)
  );

  eeprom_store #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .start(start),
    .page_base(page_base), .page_data(page_data), .page_mask(page_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(wr_busy), .done(done)
  );
endmodule

// File: rtl/spi_eeprom_checker.sv
`timescale 1ns/100ps
module spi_eeprom_checker #(
  parameter int BASE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wel,
  input logic [2:0]        bit_pos,
  input logic              wp_ok,
  input logic              cs_rise,
  input logic              cs_fall,
  input logic              frame_active,
  input logic              miso_oe,
  input logic [1:0]        blk_prot,
  input logic [BASE_W-1:0] page_base,
  input logic [15:0]       mask_bits
);
  logic locked_now;
  always_comb begin
    case (blk_prot)
      2'd0:    locked_now = 1'b0;
      2'd1:    locked_now = (page_base[BASE_W-1 -: 2] == 2'b11);
      2'd2:    locked_now = page_base[BASE_W-1];
      default: locked_now = 1'b1;
    endcase
  end

  AST_OE_DROPS_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && frame_active) |=> !miso_oe);  // R1
  AST_FRAME_NEEDS_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> $past(cs_fall));  // R2
  AST_COMMIT_ON_BYTE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bit_pos) == 3'd0));  // R4
  AST_COMMIT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));  // R6
  AST_LATCH_CLEAR_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);  // R7
  AST_COMMIT_NEEDS_WP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wp_ok));  // R8
  AST_COMMIT_OUTSIDE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(locked_now));  // R9
  AST_PAGE_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask_bits));  // R10
endmodule

bind spi_eeprom_ctrl spi_eeprom_checker #(.BASE_W(ADDR_W - COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(wr_busy), .wel(wel), .bit_pos(bit_pos),
  .wp_ok(wp_ok), .cs_rise(cs_rise), .cs_fall(cs_fall), .frame_active(frame_active),
  .miso_oe(spi_miso_oe), .blk_prot(blk_prot), .page_base(page_base),
  .mask_bits(16'(page_mask))
);

// File: tb/tb_spi_eeprom_ctrl.sv
`timescale 1ns/100ps
module tb_spi_eeprom_ctrl;
  localparam int WCYC = 600;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic [1:0] bp = 2'd0;
  logic miso, miso_oe, busy;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [512];

  always #2.5 clk = ~clk;

  spi_eeprom_ctrl #(.PAGE_BYTES(16), .WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .wp_n(wp_n), .blk_prot(bp), .spi_miso(miso), .spi_miso_oe(miso_oe), .wr_busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_off();
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic arm();
    logic [7:0] r;
    cs_on();
    xfer(8'h06, r);
    cs_off();
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 13) + (seed * 7) + 1);
  endfunction

  // Drives one write frame, then watches wr_busy for the whole window after the CS rise.
  task automatic write_frame(input logic [8:0] a, input int n, input int seed,
                             input bit extra_bits, input bit wp_glitch,
                             input bit expect_ok, input string req);
    logic [7:0] r;
    int busy_cnt;
    cs_on();
    xfer({4'h0, a[8], 3'b010}, r);
    xfer(a[7:0], r);
    chk(miso_oe == 1'b1, "R1", miso_oe, 1);
    for (int k = 0; k < n; k++) begin
      if (wp_glitch && k == 1) begin
        wp_n = 1'b0;
        tick(4);
        wp_n = 1'b1;
      end
      xfer(pat(k, seed), r);
    end
    if (extra_bits) begin
      for (int b = 0; b < 3; b++) begin
        mosi = b[0];
        tick(HALF);
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
      end
    end
    tick(HALF);
    cs_n = 1'b1;
    busy_cnt = 0;
    for (int c = 0; c < WCYC + 40; c++) begin
      @(negedge clk);
      if (busy) busy_cnt++;
    end
    chk(miso_oe == 1'b0, "R1", miso_oe, 0);
    chk(busy_cnt == (expect_ok ? WCYC : 0), req, busy_cnt, expect_ok ? WCYC : 0);
    if (expect_ok)
      for (int k = 0; k < n; k++)
        model[{a[8:4], 4'(a[3:0] + 4'(k))}] = pat(k, seed);
  endtask

  task automatic read_check(input logic [8:0] a, input int n, input string req);
    logic [7:0] r;
    cs_on();
    xfer({4'h0, a[8], 3'b011}, r);
    xfer(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      chk(r == model[9'(a + 9'(k))], req, r, model[9'(a + 9'(k))]);
    end
    cs_off();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R12: reset state at the pins
    chk(busy == 1'b0, "R12", busy, 0);
    chk(miso_oe == 1'b0, "R1", miso_oe, 0);

    // R2: CS low since reset, an arm instruction clocked in must be ignored
    xfer(8'h06, r);
    chk(miso_oe == 1'b0, "R2", miso_oe, 0);
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
    write_frame(9'h010, 1, 1, 0, 0, 0, "R2");

    // R12, R11: whole array reads back as zero, crossing 0x0FF to 0x100
    read_check(9'h000, 512, "R12");

    // R3, R5: write with address bit 8 in the instruction byte, start mid-page
    arm();
    write_frame(9'h105, 16, 2, 0, 0, 1, "R3");
    read_check(9'h100, 16, "R3");
    read_check(9'h005, 1, "R3");

    // R6: no arm, no write
    write_frame(9'h020, 2, 3, 0, 0, 0, "R6");
    read_check(9'h020, 2, "R6");

    // R5: 18 bytes into one page, the last two overwrite the first two columns
    arm();
    write_frame(9'h03A, 18, 4, 0, 0, 1, "R5");
    read_check(9'h030, 16, "R5");

    // R4: chip select rises mid-byte, then without data bytes
    arm();
    write_frame(9'h050, 2, 5, 1, 0, 0, "R4");
    arm();
    write_frame(9'h050, 0, 5, 0, 0, 0, "R4");
    // R7: the rejection cleared the latch
    write_frame(9'h050, 2, 6, 0, 0, 0, "R7");
    read_check(9'h050, 2, "R4");

    // R8: a write-protect pulse inside the frame cancels it
    arm();
    write_frame(9'h060, 3, 7, 0, 1, 0, "R8");
    read_check(9'h060, 3, "R8");
    // R8: write-protect falling after the commit started has no effect
    arm();
    cs_on();
    xfer(8'h02, r);
    xfer(8'h70, r);
    xfer(8'hA5, r);
    tick(HALF);
    cs_n = 1'b1;
    tick(12);
    wp_n = 1'b0;
    chk(busy == 1'b1, "R8", busy, 1);
    tick(WCYC + 20);
    wp_n = 1'b1;
    model[9'h070] = 8'hA5;
    read_check(9'h070, 1, "R8");
    // R7: latch cleared after that completed cycle
    write_frame(9'h071, 1, 8, 0, 0, 0, "R7");

    // R9: every protect setting against every quarter
    for (int sel = 0; sel < 4; sel++) begin
      for (int q = 0; q < 4; q++) begin
        logic [8:0] a;
        bit ok;
        a  = 9'(q * 128 + 9 + sel);
        ok = !((sel == 3) || (sel == 2 && q >= 2) || (sel == 1 && q == 3));
        bp = 2'(sel);
        arm();
        write_frame(a, 1, 10 + sel * 4 + q, 0, 0, ok, "R9");
        read_check(a, 1, "R9");
      end
    end
    bp = 2'd0;

    // R10: frames during the busy window are ignored
    arm();
    cs_on();
    xfer(8'h02, r);
    xfer(8'hC0, r);
    xfer(8'h3C, r);
    tick(HALF);
    cs_n = 1'b1;
    tick(12);
    chk(busy == 1'b1, "R10", busy, 1);
    tick(2 * HALF);
    arm();
    cs_on();
    xfer(8'h02, r);
    xfer(8'hD0, r);
    xfer(8'h99, r);
    cs_off();
    chk(busy == 1'b1, "R10", busy, 1);
    tick(WCYC);
    chk(busy == 1'b0, "R10", busy, 0);
    model[9'h0C0] = 8'h3C;
    read_check(9'h0C0, 1, "R10");
    read_check(9'h0D0, 1, "R10");
    write_frame(9'h0D0, 1, 30, 0, 0, 0, "R7");

    // R11: sequential read wrapping from the top of the array to address 0
    arm();
    write_frame(9'h1F8, 8, 31, 0, 0, 1, "R11");
    arm();
    write_frame(9'h000, 4, 32, 0, 0, 1, "R11");
    read_check(9'h1FC, 8, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule